// File: doc/BRIEF.md
# Input Change Interrupt Detector

This block watches a bank of general-purpose pins that is split into fixed-width ports. It raises an interrupt request whenever a pin configured as an input holds a level different from the one last captured for its port. Each port keeps its own snapshot of its pin levels. The snapshot is taken once when the block leaves reset. After that it is refreshed only when the bus interface signals that the input register of that port has been read.

The block receives three things: pin levels that have already been synchronized, a per-pin direction mask, and a one-cycle read strobe for each port. The strobe is pulsed in the cycle in which read data is latched for transmission. The block drives a single pull-low enable for an open-drain, active-low interrupt line. The request withdraws by itself when every mismatching input returns to its captured level. It also withdraws when the offending port is read.

Top module: `icd_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `int_pull_low` is 0. The first clock edge after release captures the current pin levels as the snapshot of every port.
- R2: When an input-configured pin (`dir_is_in` bit = 1) differs from its snapshot, `int_pull_low` is 1 after the next rising clock edge.
- R3: A pin whose `dir_is_in` bit is 0 never causes the interrupt, whatever its level does.
- R4: When all mismatching input pins return to their snapshot levels, `int_pull_low` returns to 0 after the next rising clock edge.
- R5: A strobe on `port_rd[p]` loads the levels present on port p in that cycle into its snapshot. The port's contribution is then cleared on that same edge, and later changes are judged against the new snapshot.
- R6: A read of one port leaves the snapshot and any pending change of every other port unaffected.
- R7: Switching a pin from output to input raises the interrupt if its level differs from its snapshot.
- R8: A change that appears after the read cycle is compared against the snapshot taken at the read, so it raises the interrupt again.
- R9: `int_pull_low` is a pull-low enable for an open-drain, active-low line: 1 means the line is driven low (interrupt active), 0 means it is released.
- R10: Port p occupies pin bits [p*PORT_W+PORT_W-1 : p*PORT_W] of `pin_lvl` and `dir_is_in`, and is read through `port_rd[p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PORTS*PORT_W | Synchronized pin levels |
| dir_is_in | input | NUM_PORTS*PORT_W | 1 = pin is an input, 0 = output |
| port_rd | input | NUM_PORTS | Per-port input-register read strobe |
| int_pull_low | output | 1 | Pull-low enable for the open-drain interrupt line |

## Verification
The bench uses the default build of two ports of eight pins each. This is the smallest build in which cross-port independence can be shown: a read of the low port must leave a pending change on the high port, and the reverse must hold too. Eight pins per port let one stimulus flip bits in both bytes at once, and let another mix output-configured and input-configured pins in the same port.

// File: rtl/icd_pkg.sv
package icd_pkg;

    typedef struct packed {
        logic prime;
    } icd_top_st_t;

    typedef struct packed {
        logic irq;
    } icd_merge_st_t;

endpackage

// File: rtl/icd_port_snap.sv
module icd_port_snap #(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prime,
    input  logic              rd,
    input  logic [PORT_W-1:0] pins,
    input  logic [PORT_W-1:0] dir_in,
    output logic              pend_next
);

    typedef struct packed {
        logic [PORT_W-1:0] snap;
    } snap_st_t;

    snap_st_t s_d, s_q;
    logic [PORT_W-1:0] diff;

    always_comb begin
        s_d = s_q;
        if (prime || rd) begin
            s_d.snap = pins;
        end
        diff      = (pins ^ s_d.snap) & dir_in;
        pend_next = |diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assert_snap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (s_q.snap == $past(pins)));

    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !prime) |=> $stable(s_q.snap));

endmodule

// File: rtl/icd_irq_merge.sv
module icd_irq_merge
    import icd_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_pend,
    output logic                 irq
);

    icd_merge_st_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        m_d.irq = |port_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign irq = m_q.irq;

    assert_rise_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_q.irq) |-> ($countones($past(port_pend)) > 0));

endmodule

// File: rtl/icd_top.sv
module icd_top
    import icd_pkg::*;
#(
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_lvl,
    input  logic [NUM_PORTS*PORT_W-1:0]   dir_is_in,
    input  logic [NUM_PORTS-1:0]          port_rd,
    output logic                          int_pull_low
);

    localparam int unsigned PIN_W = NUM_PORTS * PORT_W;

    icd_top_st_t t_d, t_q;
    logic [NUM_PORTS-1:0] pend;

    always_comb begin
        t_d       = t_q;
        t_d.prime = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{prime: 1'b1};
        end else begin
            t_q <= t_d;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        icd_port_snap #(.PORT_W(PORT_W)) u_snap (
            .clk      (clk),
            .rst_n    (rst_n),
            .prime    (t_q.prime),
            .rd       (port_rd[p]),
            .pins     (pin_lvl[p*PORT_W +: PORT_W]),
            .dir_in   (dir_is_in[p*PORT_W +: PORT_W]),
            .pend_next(pend[p])
        );
    end

    icd_irq_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_pend(pend),
        .irq      (int_pull_low)
    );

    assert_quiet_after_prime_R1: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.prime |=> !int_pull_low);

    assert_outputs_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_is_in == {PIN_W{1'b0}}) |=> !int_pull_low);

    assert_full_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&port_rd) |=> !int_pull_low);

endmodule

// File: tb/icd_top_bench.sv
`timescale 1ns/1ps
module icd_top_bench;

    localparam int unsigned PW = 8;
    localparam int unsigned NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   pin_lvl = 16'hA55A;
    logic [15:0]   dir_is_in = 16'hFFFF;
    logic [1:0]    port_rd = 2'b00;
    logic          int_pull_low;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sbq[$];

    always #10 clk = ~clk;

    icd_top #(.PORT_W(PW), .NUM_PORTS(NP)) u_icd_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_lvl     (pin_lvl),
        .dir_is_in   (dir_is_in),
        .port_rd     (port_rd),
        .int_pull_low(int_pull_low)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: int_pull_low=%b expected %b", tag, act, exp);
        end
    endtask

    // Driver: apply inputs at the falling edge, queue the value due after the next rise.
    task automatic step(input logic [15:0] p, input logic [15:0] d,
                        input logic [1:0] r, input logic e, input string tag);
        @(negedge clk);
        pin_lvl   = p;
        dir_is_in = d;
        port_rd   = r;
        sbq.push_back('{exp: e, tag: tag});
    endtask

    // Monitor: sample 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(int_pull_low, it.exp, it.tag);
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check(int_pull_low, 1'b0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(16'hA55A, 16'hFFFF, 2'b00, 1'b0, "R1 prime edge");
        step(16'hA55A, 16'hFFFF, 2'b00, 1'b0, "R1 no change");
        step(16'hA55B, 16'hFFFF, 2'b00, 1'b1, "R2/R9 input change");
        step(16'hA55A, 16'hFFFF, 2'b00, 1'b0, "R4 return to snapshot");
        step(16'hA55A, 16'hFFFE, 2'b00, 1'b0, "R3 make bit0 output");
        step(16'hA55B, 16'hFFFE, 2'b00, 1'b0, "R3 output pin toggles");
        step(16'hA55B, 16'hFFFF, 2'b00, 1'b1, "R7 output to input mismatch");
        step(16'hA55B, 16'hFFFF, 2'b01, 1'b0, "R5 read port0 clears");
        step(16'hA55B, 16'hFFFF, 2'b00, 1'b0, "R5 stays clear");
        step(16'hA55A, 16'hFFFF, 2'b00, 1'b1, "R5 new snapshot reference");
        step(16'hA55A, 16'hFFFF, 2'b01, 1'b0, "R5 read port0 again");
        step(16'hB55A, 16'hFFFF, 2'b01, 1'b1, "R6 port0 read keeps port1 (R10)");
        step(16'hB55A, 16'hFFFF, 2'b00, 1'b1, "R6 port1 still pending");
        step(16'hB55A, 16'hFFFF, 2'b10, 1'b0, "R5 read port1 clears");
        step(16'hB55B, 16'hFFFF, 2'b10, 1'b1, "R6 port1 read keeps port0");
        step(16'hB55B, 16'hFFFF, 2'b00, 1'b1, "R6 port0 still pending");
        step(16'hB55B, 16'hFFFF, 2'b01, 1'b0, "R5 read port0 clears");
        step(16'hB55C, 16'hFFFF, 2'b01, 1'b0, "R8 change in read cycle captured");
        step(16'hB55D, 16'hFFFF, 2'b00, 1'b1, "R8 later change raises");
        step(16'hB55D, 16'hFFFF, 2'b01, 1'b0, "R5 read port0 clears");
        step(16'h4A2D, 16'hFFFF, 2'b00, 1'b1, "R2 many pins both ports");
        step(16'h4A2D, 16'h0000, 2'b00, 1'b0, "R3 all outputs");
        step(16'h4A2D, 16'hFFFF, 2'b11, 1'b0, "R5 read both ports");
        step(16'h4A2D, 16'hFFFF, 2'b00, 1'b0, "R4 idle after full read");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule